// File: doc/BRIEF.md
# Parallel-Lane Serial Transfer Engine

This block is the datapath of a serial peripheral controller. It drives one chip select and one serial clock, and it has `N_LANES` parallel data lanes in each direction. Every lane is `LANE_W` bits wide, and the width defaults to a single bit. Each lane carries its own word. A lane never carries part of a word spread over several wires. A per-transfer mode picks one of three behaviours:

- **Single:** only logical lane 0 is used.
- **Mirror:** one transmit word is replicated onto every lane.
- **Stripe:** consecutive buffer words are dealt out round-robin over the lanes, and received lane words are gathered back into buffer order.

Two programmable maps, one for transmit and one for receive, tie each logical lane to a physical lane.

A client sets the configuration inputs and pulses `start`. On a write, the client feeds words on a valid/ready stream. On a read, it collects words from `rx_valid`/`rx_data`; this stream has no back-pressure. The transfer ends with a one-cycle `done`, and `err` is high in that cycle if the request was rejected.

The engine is one state machine with these states:

- **IDLE** waits for `start`. It goes to DONE for an illegal request, to LEAD for a read, and to FETCH for a write.
- **FETCH** accepts the transmit words of one group (one word, or `N_LANES` words in stripe mode). It then goes to LEAD.
- **LEAD** holds chip select low with the clock low for one half period. It then goes to HIGH.
- **HIGH** is the clock-high half period. Each receive lane is captured at its end. HIGH goes to LOW while beats remain in the group. After the last beat of a group it goes to one of three states:
  - PUSH on a read;
  - FETCH on a write with more groups to send;
  - TAIL after the final group of a write.
- **LOW** is the clock-low half period. The transmit registers shift on entry to LOW. LOW goes back to HIGH.
- **PUSH** emits the received words of the group, one per cycle. It then goes to LEAD when more groups remain, otherwise to TAIL.
- **TAIL** waits one half period with chip select still low. It then goes to DONE.
- **DONE** releases chip select and pulses `done`. It then goes back to IDLE.

Top module: `mlspi_engine`

## Requirements
- R1: In single mode (mode code 0) each word goes out MSB first on the physical lane named by logical lane 0's transmit map field. For example, 0x88 appears as 1,0,0,0,1,0,0,0 in rising-edge order. Every other physical transmit lane stays 0.
- R2: In mirror mode (mode code 1) the same transmit word is driven on every mapped physical lane at the same time.
- R3: In stripe mode (mode code 2) buffer word k is driven on logical lane k mod `N_LANES`, and all lanes of a group shift together.
- R4: In a stripe read, the received words of a group leave on `rx_data` in logical lane order. With 0x11 on lane 0 and 0x88 on lane 1, the order is 0x11 then 0x88.
- R5: In a single-mode read only logical lane 0 is captured. Data on the other physical lanes never appears on `rx_data`.
- R6: Logical lane l uses physical lane `map[l*MAP_W +: MAP_W]`, where `MAP_W` is clog2(`N_LANES`) (minimum 1). The transmit map and the receive map are separate.
- R7: The engine rejects a request in four cases:
  - mirror mode on a read;
  - stripe mode with a length that is not a multiple of `N_LANES`;
  - a zero length;
  - mode code 3.
  
  A rejected request raises `done` with `err` in the cycle after `start`, never lowers chip select and never asserts `tx_ready`.
- R8: The serial clock idles low and is high only while chip select is low. Chip select falls exactly one half period before the first rising clock edge.
- R9: Each half period of the serial clock lasts `cfg_div`+1 clock cycles.
- R10: `done` is a one-cycle pulse. It comes after the final group has been shifted and delivered, with chip select already high. `err` is low on a successful transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a transfer with the current configuration |
| cfg_mode | input | 2 | 0 single, 1 mirror, 2 stripe, 3 invalid |
| cfg_read | input | 1 | 1 = read transfer, 0 = write transfer |
| cfg_len | input | LEN_W | Transfer length in buffer words |
| cfg_div | input | DIV_W | Half period of the serial clock minus one, in clock cycles |
| cfg_tx_map | input | N_LANES*MAP_W | Physical lane of each logical transmit lane |
| cfg_rx_map | input | N_LANES*MAP_W | Physical lane of each logical receive lane |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | WORD_W | Transmit word |
| tx_ready | output | 1 | Engine takes `tx_data` this cycle when valid |
| rx_valid | output | 1 | Received word on `rx_data` |
| rx_data | output | WORD_W | Received word, in buffer order |
| busy | output | 1 | Engine is not idle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Request rejected; valid together with `done` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | N_LANES*LANE_W | Physical transmit lanes |
| spi_miso | input | N_LANES*LANE_W | Physical receive lanes |

## Verification
The hardest cases to reach from the ports involve steering. A swapped lane map must be shown to move data between physical wires. A single-mode read must be shown to ignore a lane that is carrying live, non-zero data. The bench models the peripheral per physical lane, with its own word queue on each lane. It checks transmit traffic wire by wire at the rising clock edges against expectations derived from the mode and the map. This way, a misrouted or duplicated lane shows up as a wrong byte on a specific wire. Rejected requests are checked by watching that chip select and `tx_ready` never move between `start` and `done`.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_MIRROR = 2'd1,
        MODE_STRIPE = 2'd2,
        MODE_BAD    = 2'd3
    } lane_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_PUSH,
        ST_TAIL,
        ST_DONE
    } eng_state_e;

endpackage

// File: rtl/mlspi_clkdiv.sv
module mlspi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the half-period counter never passes the programmed divider
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));

endmodule

// File: rtl/mlspi_lane.sv
module mlspi_lane #(
    parameter int WORD_W = 8,
    parameter int LANE_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              sample,
    input  logic [LANE_W-1:0] rx_bits,
    output logic [LANE_W-1:0] tx_bits,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;

    assign tx_bits = tx_sr[WORD_W-1 -: LANE_W];
    assign rx_word = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_word;
        end else if (shift) begin
            tx_sr <= tx_sr << LANE_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample) begin
            rx_sr <= (rx_sr << LANE_W) | WORD_W'(rx_bits);
        end
    end

endmodule

// File: rtl/mlspi_steer.sv
module mlspi_steer #(
    parameter int N_LANES = 2,
    parameter int LANE_W  = 1,
    parameter int MAP_W   = 1
) (
    input  logic [N_LANES-1:0]        active,
    input  logic [N_LANES*MAP_W-1:0]  tx_map,
    input  logic [N_LANES*MAP_W-1:0]  rx_map,
    input  logic [N_LANES*LANE_W-1:0] lane_tx,
    output logic [N_LANES*LANE_W-1:0] phys_tx,
    input  logic [N_LANES*LANE_W-1:0] phys_rx,
    output logic [N_LANES*LANE_W-1:0] lane_rx
);

    always_comb begin
        phys_tx = '0;
        for (int l = 0; l < N_LANES; l++) begin
            if (active[l] && (int'(tx_map[l*MAP_W +: MAP_W]) < N_LANES)) begin
                phys_tx[int'(tx_map[l*MAP_W +: MAP_W])*LANE_W +: LANE_W] =
                    phys_tx[int'(tx_map[l*MAP_W +: MAP_W])*LANE_W +: LANE_W]
                    | lane_tx[l*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        lane_rx = '0;
        for (int l = 0; l < N_LANES; l++) begin
            if (int'(rx_map[l*MAP_W +: MAP_W]) < N_LANES) begin
                lane_rx[l*LANE_W +: LANE_W] =
                    phys_rx[int'(rx_map[l*MAP_W +: MAP_W])*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/mlspi_engine.sv
module mlspi_engine
    import mlspi_pkg::*;
#(
    parameter int N_LANES = 2,
    parameter int LANE_W  = 1,
    parameter int WORD_W  = 8,
    parameter int LEN_W   = 8,
    parameter int DIV_W   = 8,
    localparam int MAP_W  = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [1:0]                cfg_mode,
    input  logic                      cfg_read,
    input  logic [LEN_W-1:0]          cfg_len,
    input  logic [DIV_W-1:0]          cfg_div,
    input  logic [N_LANES*MAP_W-1:0]  cfg_tx_map,
    input  logic [N_LANES*MAP_W-1:0]  cfg_rx_map,
    input  logic                      tx_valid,
    input  logic [WORD_W-1:0]         tx_data,
    output logic                      tx_ready,
    output logic                      rx_valid,
    output logic [WORD_W-1:0]         rx_data,
    output logic                      busy,
    output logic                      done,
    output logic                      err,
    output logic                      spi_cs_n,
    output logic                      spi_sck,
    output logic [N_LANES*LANE_W-1:0] spi_mosi,
    input  logic [N_LANES*LANE_W-1:0] spi_miso
);

    localparam int BEATS  = WORD_W / LANE_W;
    localparam int BCNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int IDX_W  = MAP_W;

    eng_state_e state_q, state_d;
    lane_mode_e mode_q;
    logic                     read_q;
    logic                     err_q;
    logic                     cs_act_q;
    logic [LEN_W-1:0]         left_q;
    logic [DIV_W-1:0]         div_q;
    logic [N_LANES*MAP_W-1:0] txmap_q, rxmap_q;
    logic [IDX_W-1:0]         idx_q;
    logic [BCNT_W-1:0]        bcnt_q;

    logic                      tick, run;
    logic                      req_bad;
    logic [LEN_W-1:0]          grp_words;
    logic [IDX_W-1:0]          last_idx;
    logic                      last_beat;
    logic [N_LANES-1:0]        lane_load, active;
    logic [WORD_W-1:0]         load_word;
    logic                      do_shift, do_sample;
    logic [N_LANES*LANE_W-1:0] lane_tx_flat, lane_rx_flat;
    logic [LANE_W-1:0]         lane_txb [N_LANES];
    logic [WORD_W-1:0]         rx_words [N_LANES];

    // ---------------- request check and group geometry ----------------
    always_comb begin
        req_bad = 1'b0;
        if (cfg_len == '0)                                           req_bad = 1'b1;
        if (cfg_mode == MODE_BAD)                                    req_bad = 1'b1;
        if (cfg_mode == MODE_MIRROR && cfg_read)                     req_bad = 1'b1;
        if (cfg_mode == MODE_STRIPE && (cfg_len % LEN_W'(N_LANES)) != '0) req_bad = 1'b1;
    end

    assign grp_words = (mode_q == MODE_STRIPE) ? LEN_W'(N_LANES) : LEN_W'(1);
    assign last_idx  = (mode_q == MODE_STRIPE) ? IDX_W'(N_LANES - 1) : '0;
    assign last_beat = (bcnt_q == BCNT_W'(BEATS - 1));
    assign run       = (state_q == ST_LEAD) || (state_q == ST_HIGH) ||
                       (state_q == ST_LOW)  || (state_q == ST_TAIL);

    mlspi_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = req_bad ? ST_DONE : (cfg_read ? ST_LEAD : ST_FETCH);
            ST_FETCH: if (tx_valid && idx_q == last_idx) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_HIGH;
            ST_HIGH: begin
                if (tick) begin
                    if (!last_beat)            state_d = ST_LOW;
                    else if (read_q)           state_d = ST_PUSH;
                    else if (left_q > grp_words) state_d = ST_FETCH;
                    else                       state_d = ST_TAIL;
                end
            end
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_PUSH:  if (idx_q == last_idx) state_d = (left_q != '0) ? ST_LEAD : ST_TAIL;
            ST_TAIL:  if (tick) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- transfer bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_SINGLE;
            read_q   <= 1'b0;
            err_q    <= 1'b0;
            cs_act_q <= 1'b0;
            left_q   <= '0;
            div_q    <= '0;
            txmap_q  <= '0;
            rxmap_q  <= '0;
            idx_q    <= '0;
            bcnt_q   <= '0;
        end else begin
            if (state_d == ST_LEAD)      cs_act_q <= 1'b1;
            else if (state_d == ST_DONE) cs_act_q <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= lane_mode_e'(cfg_mode);
                        read_q  <= cfg_read;
                        err_q   <= req_bad;
                        left_q  <= cfg_len;
                        div_q   <= cfg_div;
                        txmap_q <= cfg_tx_map;
                        rxmap_q <= cfg_rx_map;
                        idx_q   <= '0;
                        bcnt_q  <= '0;
                    end
                end
                ST_FETCH: begin
                    if (tx_valid) idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
                end
                ST_HIGH: begin
                    if (tick) begin
                        bcnt_q <= last_beat ? '0 : bcnt_q + 1'b1;
                        if (last_beat) left_q <= left_q - grp_words;
                    end
                end
                ST_PUSH: idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- lane controls ----------------
    assign load_word = (state_q == ST_IDLE) ? '0 : tx_data;
    assign do_shift  = (state_q == ST_HIGH) && tick && !last_beat;
    assign do_sample = (state_q == ST_HIGH) && tick;

    generate
        for (genvar l = 0; l < N_LANES; l++) begin : g_lane
            assign lane_load[l] = (state_q == ST_IDLE && start) ||
                (state_q == ST_FETCH && tx_valid &&
                 ((mode_q == MODE_MIRROR) ||
                  (mode_q == MODE_STRIPE && idx_q == IDX_W'(l)) ||
                  (mode_q == MODE_SINGLE && l == 0)));
            assign active[l] = (mode_q != MODE_SINGLE) || (l == 0);

            mlspi_lane #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (lane_load[l]),
                .load_word (load_word),
                .shift     (do_shift),
                .sample    (do_sample),
                .rx_bits   (lane_rx_flat[l*LANE_W +: LANE_W]),
                .tx_bits   (lane_txb[l]),
                .rx_word   (rx_words[l])
            );
            assign lane_tx_flat[l*LANE_W +: LANE_W] = lane_txb[l];

            if (l > 0) begin : g_mirror_chk
                // R2: in mirror mode every lane shifts the same bits as lane 0
                a_r2_mirror_equal: assert property (@(posedge clk) disable iff (!rst_n)
                    (mode_q == MODE_MIRROR && state_q == ST_HIGH) |-> (lane_txb[l] == lane_txb[0]));
            end
        end
    endgenerate

    mlspi_steer #(.N_LANES(N_LANES), .LANE_W(LANE_W), .MAP_W(MAP_W)) u_steer (
        .active  (active),
        .tx_map  (txmap_q),
        .rx_map  (rxmap_q),
        .lane_tx (lane_tx_flat),
        .phys_tx (spi_mosi),
        .phys_rx (spi_miso),
        .lane_rx (lane_rx_flat)
    );

    // ---------------- outputs ----------------
    always_comb begin
        tx_ready = (state_q == ST_FETCH);
        rx_valid = (state_q == ST_PUSH);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        err      = (state_q == ST_DONE) && err_q;
        spi_sck  = (state_q == ST_HIGH);
        spi_cs_n = !cs_act_q;
        rx_data  = '0;
        for (int l = 0; l < N_LANES; l++) begin
            if (idx_q == IDX_W'(l)) rx_data = rx_words[l];
        end
    end

    // ---------------- assertions ----------------
    // R8: clock only toggles inside an asserted chip select
    a_r8_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R9: the serial clock level changes only on a divider tick
    a_r9_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(spi_sck));

    // R10: done appears with chip select already released
    a_r10_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    // R7: a rejection answers the start of the previous cycle
    a_r7_reject_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(start));

    // R4: received words are handed out only inside the transfer
    a_r4_rx_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !spi_cs_n);

endmodule

// File: tb/tb_mlspi_engine.sv
module tb_mlspi_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_read = 1'b0;
    logic [7:0] cfg_len = 8'd0;
    logic [7:0] cfg_div = 8'd0;
    logic [1:0] cfg_tx_map = 2'b10;
    logic [1:0] cfg_rx_map = 2'b10;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_ready, rx_valid, busy, done, err, spi_cs_n, spi_sck;
    logic [7:0] rx_data;
    logic [1:0] spi_mosi, spi_miso;

    always #10 clk = ~clk;

    mlspi_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_read(cfg_read), .cfg_len(cfg_len), .cfg_div(cfg_div),
        .cfg_tx_map(cfg_tx_map), .cfg_rx_map(cfg_rx_map),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .done(done),
        .err(err), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic void check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endfunction

    // scoreboard queues
    logic [7:0] exp_tx0[$], exp_tx1[$], exp_rx[$];
    logic [7:0] per0[$], per1[$];
    logic [7:0] wv[8], pv0[8], pv1[8];
    string      cur_tag = "reset";
    bit         chk_tx = 1'b0;
    int         cur_div = 0;

    // peripheral model per physical lane
    logic [7:0] cur0 = 8'd0, cur1 = 8'd0;
    int         pbit = 0;
    assign spi_miso = {cur1[7], cur0[7]};

    // monitor state
    logic       prev_sck = 1'b0, prev_cs = 1'b1;
    logic [7:0] sh0, sh1;
    int         tbits = 0, lead_cnt = 0, hcnt = 0;
    bit         rose_yet = 1'b0, high_done = 1'b0;
    bit         cs_seen = 1'b0, rdy_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ready) rdy_seen = 1'b1;
            if (!spi_cs_n && prev_cs) begin
                cs_seen = 1'b1;
                cur0 = (per0.size() > 0) ? per0.pop_front() : 8'd0;
                cur1 = (per1.size() > 0) ? per1.pop_front() : 8'd0;
                pbit = 0; tbits = 0; lead_cnt = 0; hcnt = 0;
                rose_yet = 1'b0; high_done = 1'b0;
            end
            if (!spi_cs_n) begin
                if (!rose_yet) begin
                    if (spi_sck) begin
                        rose_yet = 1'b1;
                        check(lead_cnt == cur_div + 1, {"R8 lead ", cur_tag}, lead_cnt, cur_div + 1);
                    end else begin
                        lead_cnt++;
                    end
                end
                if (spi_sck && !prev_sck && chk_tx) begin
                    sh0 = {sh0[6:0], spi_mosi[0]};
                    sh1 = {sh1[6:0], spi_mosi[1]};
                    tbits++;
                    if (tbits == 8) begin
                        logic [7:0] e0, e1;
                        e0 = (exp_tx0.size() > 0) ? exp_tx0.pop_front() : 8'hxx;
                        e1 = (exp_tx1.size() > 0) ? exp_tx1.pop_front() : 8'hxx;
                        check(sh0 === e0, {cur_tag, " phys0"}, sh0, e0);
                        check(sh1 === e1, {cur_tag, " phys1"}, sh1, e1);
                        tbits = 0;
                    end
                end
                if (spi_sck) begin
                    hcnt++;
                end else if (prev_sck) begin
                    if (!high_done) begin
                        check(hcnt == cur_div + 1, {"R9 high ", cur_tag}, hcnt, cur_div + 1);
                        high_done = 1'b1;
                    end
                    hcnt = 0;
                    cur0 = cur0 << 1;
                    cur1 = cur1 << 1;
                    pbit++;
                    if (pbit == 8) begin
                        cur0 = (per0.size() > 0) ? per0.pop_front() : 8'd0;
                        cur1 = (per1.size() > 0) ? per1.pop_front() : 8'd0;
                        pbit = 0;
                    end
                end
            end
            if (rx_valid) begin
                logic [7:0] er;
                er = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'hxx;
                check(rx_data === er, {cur_tag, " rx"}, rx_data, er);
            end
            prev_sck = spi_sck;
            prev_cs  = spi_cs_n;
        end
    end

    // driver: builds expectations from the requirements, then runs the transfer
    task automatic xfer(input string tag, input logic [1:0] mode, input logic rd,
                        input int len, input logic [1:0] txm, input logic [1:0] rxm,
                        input int div, input bit exp_err);
        int wcnt;
        cur_tag = tag;
        cur_div = div;
        chk_tx  = !rd && !exp_err;
        if (!exp_err) begin
            if (!rd) begin
                if (mode == 2'd2) begin
                    for (int g = 0; g < len / 2; g++) begin
                        logic [7:0] p [2];
                        p[txm[0]] = wv[2*g];
                        p[txm[1]] = wv[2*g+1];
                        exp_tx0.push_back(p[0]); exp_tx1.push_back(p[1]);
                    end
                end else begin
                    for (int g = 0; g < len; g++) begin
                        logic [7:0] p [2];
                        p[0] = 8'd0; p[1] = 8'd0;
                        p[txm[0]] = wv[g];
                        if (mode == 2'd1) p[txm[1]] = wv[g];
                        exp_tx0.push_back(p[0]); exp_tx1.push_back(p[1]);
                    end
                end
            end else begin
                int ng;
                ng = (mode == 2'd2) ? len / 2 : len;
                for (int g = 0; g < ng; g++) begin
                    per0.push_back(pv0[g]); per1.push_back(pv1[g]);
                    exp_rx.push_back(rxm[0] ? pv1[g] : pv0[g]);
                    if (mode == 2'd2) exp_rx.push_back(rxm[1] ? pv1[g] : pv0[g]);
                end
            end
        end
        cs_seen = 1'b0; rdy_seen = 1'b0;
        @(negedge clk);
        cfg_mode = mode; cfg_read = rd; cfg_len = 8'(len); cfg_div = 8'(div);
        cfg_tx_map = txm; cfg_rx_map = rxm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!exp_err && !rd) begin
            for (int i = 0; i < len; i++) begin
                tx_valid = 1'b1; tx_data = wv[i];
                while (!tx_ready) @(negedge clk);
                @(negedge clk);
            end
            tx_valid = 1'b0;
        end
        wcnt = 0;
        while (!done && wcnt < 5000) begin
            @(negedge clk);
            wcnt++;
        end
        check(done == 1'b1, {"R10 done seen ", tag}, done, 1);
        check(err == exp_err, {exp_err ? "R7 err " : "R10 err ", tag}, err, exp_err);
        check(spi_cs_n == 1'b1, {"R10 cs high at done ", tag}, spi_cs_n, 1);
        if (exp_err) begin
            check(wcnt == 0, {"R7 prompt ", tag}, wcnt, 0);
            check(!cs_seen && !rdy_seen, {"R7 quiet ", tag}, {cs_seen, rdy_seen}, 0);
        end else begin
            check(exp_tx0.size() == 0 && exp_tx1.size() == 0 && exp_rx.size() == 0,
                  {"R10 all delivered ", tag}, exp_tx0.size() + exp_tx1.size() + exp_rx.size(), 0);
        end
        @(negedge clk);
        check(done == 1'b0, {"R10 pulse ", tag}, done, 0);
        per0.delete(); per1.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && !busy && !done && !tx_ready && !rx_valid,
              "reset state", {spi_cs_n, spi_sck, busy, done}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 single write, 0x88 MSB first on physical 0, physical 1 idle
        wv[0] = 8'h88;
        xfer("R1 single 0x88", 2'd0, 1'b0, 1, 2'b10, 2'b10, 1, 1'b0);
        // R1 / R9 two words, slower clock
        wv[0] = 8'hA5; wv[1] = 8'h3C;
        xfer("R1 single two words", 2'd0, 1'b0, 2, 2'b10, 2'b10, 3, 1'b0);
        // R6 single write steered to physical 1
        wv[0] = 8'h6E;
        xfer("R6 single tx remap", 2'd0, 1'b0, 1, 2'b11, 2'b10, 0, 1'b0);
        // R2 mirror write with swapped map
        wv[0] = 8'h5A; wv[1] = 8'hC3;
        xfer("R2 mirror", 2'd1, 1'b0, 2, 2'b01, 2'b10, 2, 1'b0);
        // R3 stripe write, identity map
        wv[0] = 8'h11; wv[1] = 8'h22; wv[2] = 8'h33; wv[3] = 8'h44;
        xfer("R3 stripe write", 2'd2, 1'b0, 4, 2'b10, 2'b10, 1, 1'b0);
        // R6 stripe write, swapped transmit map
        wv[0] = 8'hF0; wv[1] = 8'h0F; wv[2] = 8'h81; wv[3] = 8'h7E;
        xfer("R6 stripe tx swap", 2'd2, 1'b0, 4, 2'b01, 2'b10, 0, 1'b0);
        // R4 stripe read: 0x11 on lane 0, 0x88 on lane 1 -> 0x11, 0x88
        pv0[0] = 8'h11; pv1[0] = 8'h88; pv0[1] = 8'hC4; pv1[1] = 8'h2B;
        xfer("R4 stripe read", 2'd2, 1'b1, 4, 2'b10, 2'b10, 1, 1'b0);
        // R6 stripe read, swapped receive map
        pv0[0] = 8'h12; pv1[0] = 8'h34;
        xfer("R6 stripe rx swap", 2'd2, 1'b1, 2, 2'b10, 2'b01, 2, 1'b0);
        // R5 single read with live data on physical 1
        pv0[0] = 8'h96; pv1[0] = 8'hFF; pv0[1] = 8'h01; pv1[1] = 8'hAA;
        xfer("R5 single read", 2'd0, 1'b1, 2, 2'b10, 2'b10, 1, 1'b0);
        // R6 single read reaching physical 1 as logical 0
        pv0[0] = 8'h00; pv1[0] = 8'hB7;
        xfer("R6 single rx remap", 2'd0, 1'b1, 1, 2'b10, 2'b11, 1, 1'b0);
        // R7 rejections
        xfer("mirror read", 2'd1, 1'b1, 2, 2'b10, 2'b10, 1, 1'b1);
        xfer("stripe odd length", 2'd2, 1'b0, 3, 2'b10, 2'b10, 1, 1'b1);
        xfer("zero length", 2'd0, 1'b0, 0, 2'b10, 2'b10, 1, 1'b1);
        xfer("mode code 3", 2'd3, 1'b0, 2, 2'b10, 2'b10, 1, 1'b1);
        // after a rejection a normal transfer still works (R10)
        wv[0] = 8'h3D;
        xfer("R10 after reject", 2'd0, 1'b0, 1, 2'b10, 2'b10, 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule